// File: doc/BRIEF.md
# Timed Configuration-Unlock Protection Unit

This block guards two groups of protected resources: the configuration I/O registers and the program-memory store/load instruction. Software writes an 8-bit key into a protection register. A key that matches one group opens an access window for that group. The window is measured in instruction cycles, which an instruction-cycle strobe marks. While the window is open, the block drives an enable to the protected logic of that group and masks interrupt acceptance in the CPU.

Each window ends early when one protected write of its group is consumed. Otherwise it ends when its cycle budget runs out. A protected write that arrives while its group is locked is refused, and the block raises a one-cycle violation pulse. A read of the protection register returns one status bit for each group. All other bits read as zero.

Top module: `cfg_unlock_guard`

## Requirements
- R1: After a synchronous reset, the readback is 0x00, both group enables are low, the interrupt mask is low and the violation pulse is low.
- R2: In the cycle after the key 0xD8 is written, readback bit 0 is one and the I/O-register group enable is high. Readback bits 0 and 1 are never both one.
- R3: In the cycle after the key 0x9D is written, readback bit 1 is one and the program-memory group enable is high.
- R4: Writing any value other than 0xD8 or 0x9D changes neither which window is open nor its remaining cycle budget. This holds whether a window is open or not.
- R5: A window stays open through three instruction-cycle strobes after the key write and closes on the fourth. Clock cycles without a strobe do not use up the budget.
- R6: The interrupt mask output is high exactly while either window is open.
- R7: Writing a valid key while a window is open reloads the budget to four strobes for the newly keyed group and closes the other group's window.
- R8: A protected write whose group is open is granted in the same cycle. Its window is closed from the next cycle on.
- R9: A protected write whose group is closed is not granted. It raises the violation output for exactly one cycle, starting in the next cycle, and it leaves the other group's window untouched.
- R10: Readback bits 7 through 2 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_wr_en | input | 1 | Write strobe for the protection register |
| key_wr_data | input | 8 | Key value being written |
| key_rd_data | output | 8 | Readback: bit 0 is I/O window open, bit 1 is program-memory window open |
| instr_tick | input | 1 | One pulse per completed instruction cycle |
| prot_wr_req | input | 1 | A protected write is being attempted |
| prot_wr_grp | input | 1 | Group of the attempted write: 0 for I/O register, 1 for program memory |
| prot_wr_ok | output | 1 | Attempted write is granted (combinational) |
| viol_pulse | output | 1 | One-cycle pulse after a refused write |
| irq_mask | output | 1 | Interrupt acceptance blocked |
| ioreg_en | output | 1 | I/O-register group unlocked |
| pmem_en | output | 1 | Program-memory group unlocked |

## Verification
A wrong remaining count or a wrong group shows up at the readback and the group enables. These outputs register one cycle after the key write or after the strobe that should close the window. So the bench samples the status after every strobe, one at a time, until the window closes. If the window is left open, the interrupt mask stays high and a protected write is granted when it should be refused. The mismatch therefore shows at prot_wr_ok in the same cycle, or at viol_pulse one cycle later. Every one of the 256 key values is swept from the locked state, and every non-key value is swept into an open window, so a decode error shows in the first cycle after the faulty write.

// File: rtl/cfg_unlock_pkg.sv
package cfg_unlock_pkg;

    localparam logic [7:0] KEY_IOREG = 8'hD8;
    localparam logic [7:0] KEY_PMEM  = 8'h9D;

    typedef enum logic [1:0] {
        GRP_NONE = 2'd0,
        GRP_IO   = 2'd1,
        GRP_PM   = 2'd2
    } grp_e;

    typedef struct packed {
        logic valid;
        grp_e grp;
    } key_dec_t;

    function automatic key_dec_t decode_key(input logic [7:0] k);
        key_dec_t d;
        d.valid = 1'b0;
        d.grp   = GRP_NONE;
        if (k == KEY_IOREG) begin
            d.valid = 1'b1;
            d.grp   = GRP_IO;
        end else if (k == KEY_PMEM) begin
            d.valid = 1'b1;
            d.grp   = GRP_PM;
        end
        return d;
    endfunction

    function automatic logic [7:0] status_byte(input logic io_open, input logic pm_open);
        return {6'b000000, pm_open, io_open};
    endfunction

endpackage

// File: rtl/cfg_key_decoder.sv
module cfg_key_decoder
    import cfg_unlock_pkg::*;
(
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       load,
    output grp_e       load_grp
);
    key_dec_t dec;

    always_comb begin
        dec      = decode_key(wr_data);
        load     = wr_en && dec.valid;
        load_grp = dec.grp;
    end

    always_comb begin
        // R4
        non_key_no_load_chk: assert (!(load && !(wr_data == KEY_IOREG || wr_data == KEY_PMEM)));
    end
endmodule

// File: rtl/cfg_window_timer.sv
module cfg_window_timer
    import cfg_unlock_pkg::*;
#(
    parameter int WIN_CYCLES = 4,
    localparam int CNT_W = $clog2(WIN_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  grp_e load_grp,
    input  logic tick,
    input  logic consume,
    output logic io_open,
    output logic pm_open
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WIN_CYCLES);

    logic [CNT_W-1:0] cnt_q;
    grp_e             grp_q;
    logic             open;

    assign open    = (cnt_q != '0);
    assign io_open = open && (grp_q == GRP_IO);
    assign pm_open = open && (grp_q == GRP_PM);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            grp_q <= GRP_NONE;
        end else if (load) begin
            cnt_q <= CNT_FULL;
            grp_q <= load_grp;
        end else if (consume) begin
            cnt_q <= '0;
            grp_q <= GRP_NONE;
        end else if (tick && open) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == 1) grp_q <= GRP_NONE;
        end
    end

    // R7
    reload_full_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == CNT_FULL) && (grp_q != GRP_NONE));

    // R5
    expire_close_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !consume && tick && cnt_q == 1) |=> !io_open && !pm_open);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !consume && !tick) |=> $stable(cnt_q) && $stable(grp_q));

    // R2
    single_group_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({io_open, pm_open}));
endmodule

// File: rtl/cfg_access_gate.sv
module cfg_access_gate (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic grp_sel,
    input  logic io_open,
    input  logic pm_open,
    output logic granted,
    output logic viol
);
    logic viol_q;

    assign granted = req && (grp_sel ? pm_open : io_open);
    assign viol    = viol_q;

    always_ff @(posedge clk) begin
        if (rst) viol_q <= 1'b0;
        else     viol_q <= req && !granted;
    end

    // R9
    refused_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !(grp_sel ? pm_open : io_open)) |=> viol_q);

    // R8
    granted_no_viol_chk: assert property (@(posedge clk) disable iff (rst)
        (req && granted) |=> !viol_q);
endmodule

// File: rtl/cfg_unlock_guard.sv
module cfg_unlock_guard
    import cfg_unlock_pkg::*;
#(
    parameter int WIN_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       key_wr_en,
    input  logic [7:0] key_wr_data,
    output logic [7:0] key_rd_data,
    input  logic       instr_tick,
    input  logic       prot_wr_req,
    input  logic       prot_wr_grp,
    output logic       prot_wr_ok,
    output logic       viol_pulse,
    output logic       irq_mask,
    output logic       ioreg_en,
    output logic       pmem_en
);
    logic load;
    grp_e load_grp;
    logic io_open, pm_open;

    cfg_key_decoder u_dec (
        .wr_en    (key_wr_en),
        .wr_data  (key_wr_data),
        .load     (load),
        .load_grp (load_grp)
    );

    cfg_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_grp (load_grp),
        .tick     (instr_tick),
        .consume  (prot_wr_ok),
        .io_open  (io_open),
        .pm_open  (pm_open)
    );

    cfg_access_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .req     (prot_wr_req),
        .grp_sel (prot_wr_grp),
        .io_open (io_open),
        .pm_open (pm_open),
        .granted (prot_wr_ok),
        .viol    (viol_pulse)
    );

    assign key_rd_data = status_byte(io_open, pm_open);
    assign ioreg_en    = io_open;
    assign pmem_en     = pm_open;
    assign irq_mask    = io_open || pm_open;

    // R6
    mask_while_open_chk: assert property (@(posedge clk) disable iff (rst)
        (ioreg_en || pmem_en) |-> irq_mask);

    // R8
    consume_closes_chk: assert property (@(posedge clk) disable iff (rst)
        (prot_wr_ok && !load) |=> !irq_mask);
endmodule

// File: tb/cfg_unlock_guard_tb.sv
module cfg_unlock_guard_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       key_wr_en;
    logic [7:0] key_wr_data;
    logic [7:0] key_rd_data;
    logic       instr_tick;
    logic       prot_wr_req;
    logic       prot_wr_grp;
    logic       prot_wr_ok;
    logic       viol_pulse;
    logic       irq_mask;
    logic       ioreg_en;
    logic       pmem_en;

    int checks   = 0;
    int failures = 0;
    logic ok_pre;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_unlock_guard #(.WIN_CYCLES(4)) dut_i (
        .clk(clk), .rst(rst),
        .key_wr_en(key_wr_en), .key_wr_data(key_wr_data), .key_rd_data(key_rd_data),
        .instr_tick(instr_tick), .prot_wr_req(prot_wr_req), .prot_wr_grp(prot_wr_grp),
        .prot_wr_ok(prot_wr_ok), .viol_pulse(viol_pulse), .irq_mask(irq_mask),
        .ioreg_en(ioreg_en), .pmem_en(pmem_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One clock cycle: drive after the falling edge, note the combinational grant,
    // then sample registered outputs just after the rising edge.
    task automatic cyc(input logic kw, input logic [7:0] kd, input logic tk,
                       input logic rq, input logic gs);
        @(negedge clk);
        key_wr_en = kw; key_wr_data = kd; instr_tick = tk;
        prot_wr_req = rq; prot_wr_grp = gs;
        #1 ok_pre = prot_wr_ok;
        @(posedge clk);
        #1;
        key_wr_en = 0; key_wr_data = 0; instr_tick = 0; prot_wr_req = 0; prot_wr_grp = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        @(posedge clk);
        #1 rst = 0;
    endtask

    // Status expected from the open group: 1 = I/O, 2 = program memory, 0 = none
    task automatic chk_state(input string req, input int st);
        chk(req, key_rd_data, st);
        chk(req, ioreg_en, st == 1);
        chk(req, pmem_en, st == 2);
        chk({req, "/R6"}, irq_mask, st != 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1; key_wr_en = 0; key_wr_data = 0; instr_tick = 0;
        prot_wr_req = 0; prot_wr_grp = 0;
        @(posedge clk); #1;
        rst = 0;
        // R1: state right after reset
        chk_state("R1", 0);
        chk("R1", viol_pulse, 0);

        // Sweep all keys from the locked state: R2, R3, R4, R10, R5
        for (int k = 0; k < 256; k++) begin
            int exp;
            do_reset();
            exp = (k == 8'hD8) ? 1 : (k == 8'h9D) ? 2 : 0;
            cyc(1, 8'(k), 0, 0, 0);
            chk((exp == 1) ? "R2" : (exp == 2) ? "R3" : "R4", key_rd_data, exp);
            chk("R10", key_rd_data & 8'hFC, 0);
            chk("R6", irq_mask, exp != 0);
            if (exp != 0) begin
                cyc(0, 0, 0, 0, 0);
                cyc(0, 0, 0, 0, 0);
                chk_state("R5 idle", exp);
                for (int t = 1; t <= 4; t++) begin
                    cyc(0, 0, 1, 0, 0);
                    chk_state("R5", (t < 4) ? exp : 0);
                end
            end
        end

        // R4: every non-key value written into an open window leaves it as is
        do_reset();
        cyc(1, 8'hD8, 0, 0, 0);
        cyc(0, 0, 1, 0, 0);
        for (int k = 0; k < 256; k++) begin
            if (k != 8'hD8 && k != 8'h9D) begin
                cyc(1, 8'(k), 0, 0, 0);
                chk("R4", key_rd_data, 1);
            end
        end
        for (int t = 2; t <= 4; t++) begin
            cyc(0, 0, 1, 0, 0);
            chk_state("R4 budget", (t < 4) ? 1 : 0);
        end

        // R7: switch groups mid-window, budget reloads to four
        do_reset();
        cyc(1, 8'hD8, 0, 0, 0);
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 1, 0, 0);
        cyc(1, 8'h9D, 0, 0, 0);
        chk_state("R7", 2);
        for (int t = 1; t <= 4; t++) begin
            cyc(0, 0, 1, 0, 0);
            chk_state("R7", (t < 4) ? 2 : 0);
        end
        // R7: same-group reload
        cyc(1, 8'h9D, 0, 0, 0);
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 1, 0, 0);
        cyc(1, 8'h9D, 0, 0, 0);
        for (int t = 1; t <= 4; t++) begin
            cyc(0, 0, 1, 0, 0);
            chk_state("R7 same", (t < 4) ? 2 : 0);
        end

        // R8: granted write closes window, for each group
        for (int g = 0; g < 2; g++) begin
            do_reset();
            cyc(1, (g == 0) ? 8'hD8 : 8'h9D, 0, 0, 0);
            cyc(0, 0, 0, 1, g[0]);
            chk("R8", ok_pre, 1);
            chk_state("R8", 0);
            chk("R8", viol_pulse, 0);
        end

        // R9: wrong-group write refused; the other window remains
        for (int g = 0; g < 2; g++) begin
            do_reset();
            cyc(1, (g == 0) ? 8'hD8 : 8'h9D, 0, 0, 0);
            cyc(0, 0, 0, 1, ~g[0]);
            chk("R9", ok_pre, 0);
            chk("R9", viol_pulse, 1);
            chk_state("R9", g + 1);
            cyc(0, 0, 0, 0, 0);
            chk("R9", viol_pulse, 0);
        end

        // R9: locked writes, then a write after expiry
        do_reset();
        cyc(0, 0, 0, 1, 1);
        chk("R9", ok_pre, 0);
        chk("R9", viol_pulse, 1);
        cyc(0, 0, 0, 0, 0);
        chk("R9", viol_pulse, 0);
        cyc(1, 8'hD8, 0, 0, 0);
        for (int t = 0; t < 4; t++) cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 0);
        chk("R9 expired", ok_pre, 0);
        chk("R9 expired", viol_pulse, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule